// File: doc/BRIEF.md
# Passive LCD Scan Controller

This block sequences a passive LCD panel. It reads words from a frame buffer through a one-outstanding-read request port, walking word addresses from a base toward an end limit. It cuts each word into 4-bit pixel nibbles and streams them out with a valid strobe. It also drives three panel controls: a frame marker, a single-cycle line-load strobe and an alternating DF polarity line.

Software gives the panel size in pixels, a depth code and a split-panel flag. The block works out how many nibbles make up one row and how many rows make up one frame. It starts a frame only when both the video-enable and display-on controls are set. A freeze request lets the current frame finish and then parks the engine. Clearing the freeze request restarts the scan from the base address.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: Each row carries a fixed number of nibbles. When the depth code is 3 (8-bit colour) and split mode is off, the count is (width/8)*3. For depth codes 0 (monochrome), 1 (2-bit grey) and 2 (4-bit grey), and for split mode at any depth, the count is width/4.
- R2: A frame has height rows. In split mode it has height/2 rows. Every row ends with exactly one line-load pulse.
- R3: The line-load pulse lasts one clock cycle. No nibble is valid in that cycle.
- R4: The frame output is high in every cycle of the first row of a frame, including that row's line-load cycle. It is low in the line-load and nibble cycles of every later row.
- R5: One read request is issued per 16-bit word, and the request is a one-cycle pulse. The word's nibbles leave least-significant first as one continuous stream, so a row may start in the middle of a word. A frame of N nibbles issues ceil(N/4) requests.
- R6: Request addresses step by one word. The next address wraps to the base once it would reach the end limit, so no request is ever at or beyond the end limit. Each frame restarts at the base address, nibble 0.
- R7: DF is 0 after reset. It toggles exactly once per frame, in the cycle after the last row's line-load.
- R8: If freeze is raised during a frame, that frame completes and the engine then stops with no further nibbles. Lowering freeze starts a new frame from the base address.
- R9: Lowering enable or display-on stops the stream on the next clock, with strobe, data and requests all low. Raising both again starts a new frame from the base address.
- R10: When invert is high, the nibble value is inverted. When the strobe is low, vdat is 0.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 2 | Depth code: 0 mono, 1 2-bit grey, 2 4-bit grey, 3 8-bit colour |
| cfg_split | input | 1 | Split-panel mode |
| cfg_width | input | WIDTH_W | Panel width in pixels |
| cfg_height | input | HEIGHT_W | Panel height in pixels |
| cfg_base | input | ADDR_W | Frame-buffer base word address |
| cfg_end | input | ADDR_W | Exclusive end word address |
| cfg_enable | input | 1 | Video logic enable |
| cfg_disp_on | input | 1 | Display on |
| cfg_freeze | input | 1 | Stop at end of current frame |
| cfg_invert | input | 1 | Invert the pixel nibble |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | ADDR_W | Read word address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | WORD_W | Read data word |
| vdat | output | 4 | Pixel nibble |
| vdat_valid | output | 1 | Nibble strobe |
| lcd_frame | output | 1 | First-row marker |
| lcd_load | output | 1 | Line-load pulse |
| lcd_df | output | 1 | Alternating DF polarity |

## Verification
Several properties are checked on every cycle: the single-cycle shape of the load and request pulses, the idle-zero data, the one-cycle stop after enable or display-on drops, DF changing only after a line-load, and request addresses staying inside the base and end window. Other behaviours can only be shown by the bench scenarios, because they depend on the panel geometry. These are the row length for each depth and split combination, the row count, the exact nibble order across word and line boundaries, address wrap and restart, frame-marker placement, DF alternation, and whether a frozen frame is completed before the engine stops.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_REQ,
        ST_WAIT,
        ST_SHIFT,
        ST_LOAD
    } scan_state_e;

    localparam logic [1:0] DEPTH_COLOR8 = 2'd3;
    localparam int         NIB_W        = 4;
endpackage

// File: rtl/lcd_geom.sv
module lcd_geom
    import lcd_scan_pkg::*;
#(
    parameter int WIDTH_W  = 10,
    parameter int HEIGHT_W = 9
) (
    input  logic [1:0]          depth,
    input  logic                split,
    input  logic [WIDTH_W-1:0]  width,
    input  logic [HEIGHT_W-1:0] height,
    output logic [WIDTH_W-1:0]  row_last,
    output logic [HEIGHT_W-1:0] line_last
);
    localparam logic [WIDTH_W-1:0]  ONE_C = WIDTH_W'(1);
    localparam logic [HEIGHT_W-1:0] ONE_L = HEIGHT_W'(1);

    logic [WIDTH_W-1:0]  units;
    logic [HEIGHT_W-1:0] lines;

    always_comb begin
        if (depth == DEPTH_COLOR8 && !split) begin
            units = WIDTH_W'((width >> 3) * 3);
        end else begin
            units = width >> 2;
        end
        lines     = split ? (height >> 1) : height;
        row_last  = units - ONE_C;
        line_last = lines - ONE_L;
    end
endmodule

// File: rtl/lcd_addr_walker.sv
module lcd_addr_walker #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } walk_t;

    walk_t             walk_d, walk_q;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        walk_d    = walk_q;
        next_addr = walk_q.addr + ADDR_W'(1);
        if (restart) begin
            walk_d.addr = base;
        end else if (step) begin
            walk_d.addr = (next_addr >= end_addr) ? base : next_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign addr = walk_q.addr;
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int WIDTH_W  = 10,
    parameter int HEIGHT_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_ok,
    input  logic                freeze,
    input  logic [WIDTH_W-1:0]  row_last,
    input  logic [HEIGHT_W-1:0] line_last,
    input  logic                rd_valid,
    input  logic [WORD_W-1:0]   rd_data,
    output logic                rd_req,
    output logic                walk_restart,
    output logic                walk_step,
    output logic [NIB_W-1:0]    nib_out,
    output logic                nib_valid,
    output logic                line_load,
    output logic                frame,
    output logic                df
);
    localparam int NIBS      = WORD_W / NIB_W;
    localparam int NIB_IDX_W = $clog2(NIBS);
    localparam logic [NIB_IDX_W-1:0] NIB_LAST = NIB_IDX_W'(NIBS - 1);

    typedef struct packed {
        scan_state_e          st;
        logic [NIB_IDX_W-1:0] nib;
        logic [WIDTH_W-1:0]   col;
        logic [HEIGHT_W-1:0]  row;
        logic [WORD_W-1:0]    buf_w;
        logic                 df;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d        = seq_q;
        walk_restart = 1'b0;
        walk_step    = 1'b0;
        if (!run_ok) begin
            seq_d.st = ST_OFF;
        end else begin
            unique case (seq_q.st)
                ST_OFF: begin
                    if (!freeze) begin
                        walk_restart = 1'b1;
                        seq_d.row    = '0;
                        seq_d.col    = '0;
                        seq_d.nib    = '0;
                        seq_d.st     = ST_REQ;
                    end
                end
                ST_REQ: begin
                    walk_step = 1'b1;
                    seq_d.st  = ST_WAIT;
                end
                ST_WAIT: begin
                    if (rd_valid) begin
                        seq_d.buf_w = rd_data;
                        seq_d.nib   = '0;
                        seq_d.st    = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    seq_d.nib = seq_q.nib + NIB_IDX_W'(1);
                    if (seq_q.col == row_last) begin
                        seq_d.col = '0;
                        seq_d.st  = ST_LOAD;
                    end else begin
                        seq_d.col = seq_q.col + WIDTH_W'(1);
                        if (seq_q.nib == NIB_LAST) seq_d.st = ST_REQ;
                    end
                end
                ST_LOAD: begin
                    if (seq_q.row == line_last) begin
                        seq_d.df  = ~seq_q.df;
                        seq_d.row = '0;
                        if (freeze) begin
                            seq_d.st = ST_OFF;
                        end else begin
                            walk_restart = 1'b1;
                            seq_d.nib    = '0;
                            seq_d.st     = ST_REQ;
                        end
                    end else begin
                        seq_d.row = seq_q.row + HEIGHT_W'(1);
                        seq_d.st  = (seq_q.nib == '0) ? ST_REQ : ST_SHIFT;
                    end
                end
                default: seq_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_OFF;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req    = (seq_q.st == ST_REQ);
    assign nib_valid = (seq_q.st == ST_SHIFT);
    assign line_load = (seq_q.st == ST_LOAD);
    assign frame     = (seq_q.st != ST_OFF) && (seq_q.row == '0);
    assign df        = seq_q.df;
    assign nib_out   = seq_q.buf_w[{seq_q.nib, 2'b00} +: NIB_W];
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WORD_W   = 16,
    parameter int WIDTH_W  = 10,
    parameter int HEIGHT_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_depth,
    input  logic                cfg_split,
    input  logic [WIDTH_W-1:0]  cfg_width,
    input  logic [HEIGHT_W-1:0] cfg_height,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [ADDR_W-1:0]   cfg_end,
    input  logic                cfg_enable,
    input  logic                cfg_disp_on,
    input  logic                cfg_freeze,
    input  logic                cfg_invert,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rd_valid,
    input  logic [WORD_W-1:0]   rd_data,
    output logic [3:0]          vdat,
    output logic                vdat_valid,
    output logic                lcd_frame,
    output logic                lcd_load,
    output logic                lcd_df
);
    logic [WIDTH_W-1:0]  row_last;
    logic [HEIGHT_W-1:0] line_last;
    logic                walk_restart;
    logic                walk_step;
    logic [NIB_W-1:0]    nib;
    logic                nib_valid;

    lcd_geom #(.WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)) u_geom (
        .depth     (cfg_depth),
        .split     (cfg_split),
        .width     (cfg_width),
        .height    (cfg_height),
        .row_last  (row_last),
        .line_last (line_last)
    );

    lcd_addr_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (walk_restart),
        .step     (walk_step),
        .base     (cfg_base),
        .end_addr (cfg_end),
        .addr     (rd_addr)
    );

    lcd_scan_seq #(.WORD_W(WORD_W), .WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_ok       (cfg_enable && cfg_disp_on),
        .freeze       (cfg_freeze),
        .row_last     (row_last),
        .line_last    (line_last),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_req       (rd_req),
        .walk_restart (walk_restart),
        .walk_step    (walk_step),
        .nib_out      (nib),
        .nib_valid    (nib_valid),
        .line_load    (lcd_load),
        .frame        (lcd_frame),
        .df           (lcd_df)
    );

    assign vdat_valid = nib_valid;
    assign vdat       = nib_valid ? (nib ^ {NIB_W{cfg_invert}}) : '0;
endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_disp_on,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_end,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [3:0]        vdat,
    input logic              vdat_valid,
    input logic              lcd_load,
    input logic              lcd_df
);
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_load |=> !lcd_load); // R3
    AST_LOAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_load |-> !vdat_valid); // R3
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R5
    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr >= cfg_base && rd_addr < cfg_end)); // R6
    AST_DF_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_load |=> $stable(lcd_df)); // R7
    AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_enable && cfg_disp_on) |=> (!vdat_valid && !rd_req)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vdat_valid |-> (vdat == 4'h0)); // R10
endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_disp_on (cfg_disp_on),
    .cfg_base    (cfg_base),
    .cfg_end     (cfg_end),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .vdat        (vdat),
    .vdat_valid  (vdat_valid),
    .lcd_load    (lcd_load),
    .lcd_df      (lcd_df)
);

// File: tb/lcd_scan_ctrl_test.sv
module lcd_scan_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 16;
    localparam int WIDTH_W = 10;
    localparam int HEIGHT_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_depth = '0;
    logic cfg_split = 1'b0;
    logic [WIDTH_W-1:0] cfg_width = '0;
    logic [HEIGHT_W-1:0] cfg_height = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [ADDR_W-1:0] cfg_end = 16'd1;
    logic cfg_enable = 1'b0, cfg_disp_on = 1'b0, cfg_freeze = 1'b0, cfg_invert = 1'b0;
    logic rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [WORD_W-1:0] rd_data = '0;
    logic [3:0] vdat;
    logic vdat_valid, lcd_frame, lcd_load, lcd_df;

    lcd_scan_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WIDTH_W(WIDTH_W), .HEIGHT_W(HEIGHT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_split(cfg_split),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_base(cfg_base),
        .cfg_end(cfg_end), .cfg_enable(cfg_enable), .cfg_disp_on(cfg_disp_on),
        .cfg_freeze(cfg_freeze), .cfg_invert(cfg_invert), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .vdat(vdat),
        .vdat_valid(vdat_valid), .lcd_frame(lcd_frame), .lcd_load(lcd_load),
        .lcd_df(lcd_df)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int a);
        return 16'((a * 40503 + 12345) ^ (a << 9));
    endfunction

    // monitor model state
    bit mon_on = 0;
    int mon_units = 1, mon_lines = 1, mon_base = 0, mon_end = 1;
    bit mon_inv = 0;
    int mon_row = 0, mon_col = 0, mon_k = 0, mon_frames = 0, mon_nibs = 0;
    int req_cnt = 0;
    bit prev_load = 0;
    bit exp_df = 0;
    bit pend = 0;
    int pend_addr = 0;

    function automatic int exp_nib(input int k);
        int w;
        w = mon_base + (k / 4) % (mon_end - mon_base);
        return int'((word_of(w) >> (4 * (k % 4))) & 16'hF) ^ (mon_inv ? 15 : 0);
    endfunction

    // memory responder: one-cycle turnaround, sampled away from the active edge
    always @(negedge clk) begin
        rd_valid = pend;
        rd_data  = word_of(pend_addr);
        pend     = rd_req;
        if (rd_req) begin
            pend_addr = int'(rd_addr);
            req_cnt++;
        end
    end

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (vdat_valid) begin
                chk(int'(vdat) == exp_nib(mon_k), "R5/R6/R10 nibble", int'(vdat), exp_nib(mon_k));
                chk(lcd_frame == (mon_row == 0), "R4 frame on nibble", int'(lcd_frame), int'(mon_row == 0));
                mon_col++;
                mon_k++;
                mon_nibs++;
            end
            if (lcd_load) begin
                chk(mon_col == mon_units, "R1 row length", mon_col, mon_units);
                chk(!prev_load, "R3 single load", int'(prev_load), 0);
                chk(lcd_frame == (mon_row == 0), "R4 frame on load", int'(lcd_frame), int'(mon_row == 0));
                mon_col = 0;
                if (mon_row == mon_lines - 1) begin
                    chk(lcd_df == exp_df, "R7 df before toggle", int'(lcd_df), int'(exp_df));
                    chk(req_cnt == (mon_frames + 1) * ((mon_units * mon_lines + 3) / 4),
                        "R5 requests per frame", req_cnt,
                        (mon_frames + 1) * ((mon_units * mon_lines + 3) / 4));
                    exp_df = ~exp_df;
                    mon_row = 0;
                    mon_k = 0;
                    mon_frames++;
                end else begin
                    mon_row++;
                end
            end
            prev_load = lcd_load;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic mon_reset();
        mon_row = 0; mon_col = 0; mon_k = 0; mon_frames = 0; req_cnt = 0; prev_load = 0;
    endtask

    task automatic setup(input int d, input int s, input int w, input int h,
                         input int base, input int lim, input bit inv);
        cfg_enable = 0; mon_on = 0;
        tick(3);
        cfg_depth = 2'(d); cfg_split = s[0]; cfg_width = WIDTH_W'(w);
        cfg_height = HEIGHT_W'(h); cfg_base = ADDR_W'(base); cfg_end = ADDR_W'(lim);
        cfg_invert = inv;
        mon_units = (d == 3 && s == 0) ? (w / 8) * 3 : w / 4;
        mon_lines = (s != 0) ? h / 2 : h;
        mon_base = base; mon_end = lim; mon_inv = inv;
        mon_reset();
        mon_on = 1;
        cfg_disp_on = 1;
        cfg_enable = 1;
    endtask

    task automatic wait_frames(input int n);
        while (mon_frames < n) tick(1);
    endtask

    int saved;

    initial begin
        tick(2);
        chk(vdat_valid == 0 && rd_req == 0, "R11 reset strobe/req", int'(vdat_valid) + int'(rd_req), 0);
        chk(lcd_load == 0 && lcd_frame == 0 && lcd_df == 0, "R11 reset controls",
            int'(lcd_load) + int'(lcd_frame) + int'(lcd_df), 0);
        chk(vdat == 0, "R11 reset data", int'(vdat), 0);
        rst_n = 1;
        tick(2);

        // sweep every depth code and split setting (R1, R2, R4, R5, R6, R7, R10)
        for (int d = 0; d < 4; d++) begin
            for (int s = 0; s < 2; s++) begin
                setup(d, s, 24, 6, 64 + 8 * d + s, 64 + 8 * d + s + 5, (d == 2 && s == 1));
                wait_frames(2);
                chk(mon_nibs > 0, "R2 frames completed", mon_frames, 2);
            end
        end

        // long buffer, no wrap, row length not a multiple of four (R1 R6)
        setup(3, 0, 40, 2, 256, 512, 0);
        wait_frames(3);
        chk(mon_frames == 3, "R6 no-wrap frames", mon_frames, 3);

        // freeze mid-frame (R8)
        setup(0, 0, 16, 4, 32, 35, 0);
        wait_frames(1);
        while (mon_row != 1) tick(1);
        cfg_freeze = 1;
        tick(300);
        chk(mon_frames == 2, "R8 frozen frame finished", mon_frames, 2);
        chk(mon_row == 0 && mon_col == 0, "R8 stopped on frame edge", mon_row + mon_col, 0);
        saved = mon_nibs;
        tick(100);
        chk(mon_nibs == saved, "R8 no nibbles while frozen", mon_nibs - saved, 0);
        chk(vdat_valid == 0 && lcd_load == 0, "R8 idle outputs", int'(vdat_valid) + int'(lcd_load), 0);
        req_cnt = 0;
        mon_frames = 0;
        cfg_freeze = 0;
        wait_frames(2);
        chk(mon_frames == 2, "R8 restart from base", mon_frames, 2);

        // display-on drop mid-frame (R9)
        while (mon_row != 1 || mon_col != 2) tick(1);
        mon_on = 0;
        cfg_disp_on = 0;
        tick(1);
        chk(vdat_valid == 0 && rd_req == 0, "R9 stop next cycle", int'(vdat_valid) + int'(rd_req), 0);
        chk(vdat == 0, "R9 data zero when stopped", int'(vdat), 0);
        tick(20);
        chk(vdat_valid == 0 && lcd_load == 0, "R9 stays stopped", int'(vdat_valid) + int'(lcd_load), 0);
        mon_reset();
        exp_df = lcd_df;
        mon_on = 1;
        cfg_disp_on = 1;
        wait_frames(1);
        chk(mon_frames == 1, "R9 restart from base", mon_frames, 1);

        // enable drop (R9)
        mon_on = 0;
        cfg_enable = 0;
        tick(1);
        chk(vdat_valid == 0 && rd_req == 0, "R9 enable stop", int'(vdat_valid) + int'(rd_req), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule